// File: doc/BRIEF.md
# Quadrant Sine-Cosine Bridge PWM with Tracking

This block drives one full-circle air-core gauge. The gauge has two coils, a sine coil and a cosine coil, and each coil sits in a full bridge with a plus pin and a minus pin. The block takes a 16-bit command word with a write strobe. The word holds a 9-bit angle within a quadrant, a 2-bit quadrant number and a tracking-enable bit. A free-running 9-bit counter advances on an oscillator clock enable. The counter sets a PWM period of 512 ticks. The block compares the counter against two duties read from a quarter-wave sine table. Each resulting pulse train goes to one pin of its coil's bridge, and the quadrant selects which pin.

When tracking is requested, the block rejects a write whose quadrant jumps across the circle from the last accepted quadrant. It then raises an error flag and keeps the previous value. An accepted value waits in a pending register and takes over only at the next period boundary, so a pulse is never cut in the middle of a period. The last write before the boundary is the one applied. The outputs stay low from reset until the first value is applied.

Top module: `gauge_bridge_pwm`

## Requirements
- R1: The angle is read from command bits 14 down to 6, with angle bit k at command bit 14-k, so bit 14 is the least significant. The quadrant is command bits 5:4. Tracking is enabled by command bit 0. Bits 15 and 3:1 have no effect.
- R2: The PWM counter advances only on cycles where `tick` is high, and one period lasts 512 ticks.
- R3: The duty for table index i is round(511·sin(i·90°/512)). The sine duty uses the angle as the index, and the cosine duty uses 511 minus the angle. A pin carrying a duty d is high for exactly d ticks of each period.
- R4: The quadrant steers the pulses as follows. Quadrant 0: sine on `sin_pos`, cosine on `cos_pos`. Quadrant 1: cosine on `sin_pos`, sine on `cos_neg`. Quadrant 2: sine on `sin_neg`, cosine on `cos_neg`. Quadrant 3: cosine on `sin_neg`, sine on `cos_pos`. Every other pin is 0, so both pins of one coil are never high together.
- R5: With tracking enabled, a write is accepted when its quadrant equals the last accepted quadrant or differs from it by one modulo 4 (3 and 0 are adjacent). A write that differs by two is rejected, and the previously accepted value stays in force.
- R6: With tracking disabled, every write is accepted, whatever its quadrant.
- R7: `trk_err` is 0 after reset. It is 1 in the cycle after a rejected write and 0 in the cycle after an accepted write. It does not change in any other cycle.
- R8: An accepted value reaches the outputs only at the next period boundary. If a second accepted write arrives before that boundary, the second write replaces the first.
- R9: After reset all four outputs are 0, and the reference quadrant for tracking is 0. This lasts until the first accepted value has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator clock enable that advances the PWM counter |
| wr_stb | input | 1 | One-cycle strobe that marks a valid command word |
| cmd | input | 16 | Command word holding angle, quadrant and tracking bit |
| sin_pos | output | 1 | Sine coil, plus side of the bridge |
| sin_neg | output | 1 | Sine coil, minus side of the bridge |
| cos_pos | output | 1 | Cosine coil, plus side of the bridge |
| cos_neg | output | 1 | Cosine coil, minus side of the bridge |
| trk_err | output | 1 | Quadrant-tracking error flag |

## Verification
The assertions check several rules on every cycle. They check that the error flag rises or falls one cycle after each write according to the quadrant distance, and that it holds otherwise. They check that a rejected write leaves the pending value untouched, that the applied value changes only at a period boundary, that the counter stalls without `tick`, and that a coil never has both bridge pins high. The outputs must also stay silent before the first value is applied. Only the bench's scenarios can show that the duties match the sine formula, that the bit-reversed angle field is decoded correctly, and that the last write before a boundary wins. The bench sweeps angles across all four quadrants and counts high ticks over whole periods.

// File: rtl/gauge_bridge_pwm.sv
module gauge_bridge_pwm #(
  parameter int ANG_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_stb,
  input  logic [15:0] cmd,
  output logic        sin_pos,
  output logic        sin_neg,
  output logic        cos_pos,
  output logic        cos_neg,
  output logic        trk_err
);
  localparam int STEPS  = 1 << ANG_W;
  localparam int TOP    = STEPS - 1;
  localparam int ANG_HI = 14;
  localparam int Q_LO   = ANG_HI - ANG_W - 1;

  function automatic logic [ANG_W-1:0] sine_duty(input int idx);
    real ph;
    ph = 3.14159265358979 * 0.5 * real'(idx) / real'(STEPS);
    return ANG_W'($rtoi(real'(TOP) * $sin(ph) + 0.5));
  endfunction

  logic [ANG_W-1:0] rom [STEPS];
  for (genvar i = 0; i < STEPS; i++) begin : g_rom
    localparam logic [ANG_W-1:0] VAL = sine_duty(i);
    assign rom[i] = VAL;
  end

  logic [ANG_W-1:0] cnt, pend_ang, act_ang, new_ang;
  logic [1:0]       pend_q, act_q;
  logic             pend_v, live;

  always_comb
    for (int k = 0; k < ANG_W; k++) new_ang[k] = cmd[ANG_HI-k];

  wire [1:0] new_q = cmd[Q_LO+1:Q_LO];
  wire [1:0] qdist = new_q - pend_q;
  wire       jump  = cmd[0] && (qdist == 2'd2);
  wire       take  = wr_stb && !jump;
  wire       bound = tick && (cnt == ANG_W'(TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pend_ang <= '0;
      pend_q   <= '0;
      pend_v   <= 1'b0;
      act_ang  <= '0;
      act_q    <= '0;
      live     <= 1'b0;
      trk_err  <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (bound && pend_v) begin
        act_ang <= pend_ang;
        act_q   <= pend_q;
        live    <= 1'b1;
      end
      if (take) begin
        pend_ang <= new_ang;
        pend_q   <= new_q;
        pend_v   <= 1'b1;
      end else if (bound) begin
        pend_v   <= 1'b0;
      end
      if (wr_stb) trk_err <= jump;
    end
  end

  wire s_on = live && (cnt < rom[act_ang]);
  wire c_on = live && (cnt < rom[~act_ang]);

  assign sin_pos = (act_q == 2'd0 && s_on) || (act_q == 2'd1 && c_on);
  assign sin_neg = (act_q == 2'd2 && s_on) || (act_q == 2'd3 && c_on);
  assign cos_pos = (act_q == 2'd0 && c_on) || (act_q == 2'd3 && s_on);
  assign cos_neg = (act_q == 2'd1 && s_on) || (act_q == 2'd2 && c_on);
endmodule

// File: rtl/gauge_bridge_pwm_chk.sv
module gauge_bridge_pwm_chk #(
  parameter int ANG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_stb,
  input logic [15:0]      cmd,
  input logic             sin_pos,
  input logic             sin_neg,
  input logic             cos_pos,
  input logic             cos_neg,
  input logic             trk_err,
  input logic [ANG_W-1:0] cnt,
  input logic [ANG_W-1:0] pend_ang,
  input logic [ANG_W-1:0] act_ang,
  input logic [1:0]       pend_q,
  input logic [1:0]       act_q,
  input logic             live
);
  localparam logic [ANG_W-1:0] LAST = '1;
  wire reject = wr_stb && cmd[0] && (2'(cmd[5:4] - pend_q) == 2'd2);

  // R4
  coil_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sin_pos && sin_neg) && !(cos_pos && cos_neg));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !(sin_pos || sin_neg || cos_pos || cos_neg));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> trk_err);

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !reject) |=> !trk_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(trk_err));

  // R5
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(pend_q) && $stable(pend_ang)));

  // R8
  apply_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == LAST) |=> ($stable(act_ang) && $stable(act_q)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

bind gauge_bridge_pwm gauge_bridge_pwm_chk #(.ANG_W(ANG_W)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb), .cmd(cmd),
  .sin_pos(sin_pos), .sin_neg(sin_neg), .cos_pos(cos_pos), .cos_neg(cos_neg),
  .trk_err(trk_err), .cnt(cnt), .pend_ang(pend_ang), .act_ang(act_ang),
  .pend_q(pend_q), .act_q(act_q), .live(live)
);

// File: tb/gauge_bridge_pwm_test.sv
`timescale 1ns/1ps
module gauge_bridge_pwm_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_stb = 1'b0, half = 1'b0;
  logic [15:0] cmd = '0;
  logic sin_pos, sin_neg, cos_pos, cos_neg, trk_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gauge_bridge_pwm uut (.*);

  always #4 clk = ~clk;
  always @(negedge clk) tick <= half ? ~tick : 1'b1;

  function automatic int duty(input int i);
    return $rtoi(511.0 * $sin(3.14159265358979 * 0.5 * real'(i) / 512.0) + 0.5);
  endfunction

  function automatic logic [15:0] mk(input int a, input int q, input bit t, input bit junk);
    logic [15:0] w = '0;
    for (int k = 0; k < 9; k++) w[14-k] = a[k];
    w[5:4] = q[1:0];
    w[0]   = t;
    if (junk) begin w[15] = 1'b1; w[3:1] = 3'b101; end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk); cmd = w; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic pins(input int a, input int q, input int scale, input string req);
    int s, c, e[4], m[4];
    s = duty(a); c = duty(511 - a);
    e = '{0, 0, 0, 0};
    case (q)
      0: begin e[0] = s; e[2] = c; end
      1: begin e[0] = c; e[3] = s; end
      2: begin e[1] = s; e[3] = c; end
      default: begin e[1] = c; e[2] = s; end
    endcase
    m = '{0, 0, 0, 0};
    for (int i = 0; i < 512 * scale; i++) begin
      @(negedge clk);
      m[0] += int'(sin_pos); m[1] += int'(sin_neg);
      m[2] += int'(cos_pos); m[3] += int'(cos_neg);
    end
    for (int p = 0; p < 4; p++)
      chk(m[p] == e[p] * scale, req, $sformatf("a=%0d q=%0d pin%0d high ticks", a, q, p), m[p], e[p] * scale);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk(!sin_pos && !sin_neg && !cos_pos && !cos_neg, "R9", "outputs in reset", 0, 0);
    chk(trk_err == 1'b0, "R7", "error flag in reset", int'(trk_err), 0);
    rst_n = 1'b1;
    settle(2);
    // R8 deferred: counter is near 4, boundary far away
    wr(mk(100, 0, 1'b0, 1'b0));
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      bad += int'(sin_pos || sin_neg || cos_pos || cos_neg);
    end
    chk(bad == 0, "R8", "outputs before boundary", bad, 0);
    settle(300);
    pins(100, 0, 1, "R3");

    // R8 last write wins
    wr(mk(200, 1, 1'b0, 1'b0));
    wr(mk(300, 1, 1'b0, 1'b0));
    settle(520);
    pins(300, 1, 1, "R8");

    // R1 R3 R4 R6 sweep, tracking off
    for (int i = 0; i < 15; i++) begin
      int a;
      a = (i == 14) ? 511 : i * 37;
      for (int q = 0; q < 4; q++) begin
        wr(mk(a, q, 1'b0, 1'b0));
        chk(trk_err == 1'b0, "R6", "no error with tracking off", int'(trk_err), 0);
        settle(520);
        pins(a, q, 1, (q[0] ? "R4" : "R3"));
      end
    end

    // R1 ignored bits
    wr(mk(1, 2, 1'b0, 1'b1));
    settle(520);
    pins(1, 2, 1, "R1");

    // R5 R7 tracking
    wr(mk(50, 0, 1'b0, 1'b0));
    wr(mk(60, 1, 1'b1, 1'b0));
    chk(trk_err == 1'b0, "R7", "adjacent 0->1", int'(trk_err), 0);
    wr(mk(70, 3, 1'b1, 1'b0));
    chk(trk_err == 1'b1, "R7", "jump 1->3", int'(trk_err), 1);
    settle(5);
    chk(trk_err == 1'b1, "R7", "flag held", int'(trk_err), 1);
    settle(520);
    pins(60, 1, 1, "R5");
    wr(mk(80, 2, 1'b1, 1'b0));
    chk(trk_err == 1'b0, "R7", "adjacent 1->2 clears", int'(trk_err), 0);
    wr(mk(90, 0, 1'b1, 1'b0));
    chk(trk_err == 1'b1, "R5", "jump 2->0", int'(trk_err), 1);
    wr(mk(91, 3, 1'b1, 1'b0));
    chk(trk_err == 1'b0, "R5", "adjacent 2->3", int'(trk_err), 0);
    wr(mk(92, 0, 1'b1, 1'b0));
    chk(trk_err == 1'b0, "R5", "wrap 3->0", int'(trk_err), 0);
    wr(mk(93, 0, 1'b1, 1'b0));
    chk(trk_err == 1'b0, "R5", "same quadrant", int'(trk_err), 0);
    settle(520);
    pins(93, 0, 1, "R5");
    wr(mk(94, 2, 1'b0, 1'b0));
    chk(trk_err == 1'b0, "R6", "jump with tracking off", int'(trk_err), 0);
    settle(520);
    pins(94, 2, 1, "R6");

    // R2 half-rate tick
    half = 1'b1;
    wr(mk(400, 3, 1'b0, 1'b0));
    settle(1100);
    pins(400, 3, 2, "R2");
    half = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule